// File: doc/BRIEF.md
# Time-of-day aligned periodic pulse generator

The block drives a single pulse output whose edges fall on absolute instants of a PTP time-of-day. Software sets three time values: the instant of the first rising edge, the spacing between rising edges, and the high time. Each value holds 64 bits of seconds, 32 bits of nanoseconds (0 to 999,999,999) and 32 bits of sub-nanosecond fraction. The block keeps the times of the next rising edge and the next falling edge. It compares both against the live time-of-day every clock and toggles the output when the live time reaches them.

After any setting changes, the block reloads its edge times from the programmed start. It then moves them forward by one period per clock until the rising edge is no longer in the past, and then reports lock. If the time source is stepped while the block is locked, the block loses lock, flags an error and repeats the search. Settings span four 32-bit words each. They are written through a word-addressed register port and take effect as a whole only when their top word is written.

Top module: `tod_pulse_gen`

## Requirements
- R1: Word 0 reads 0x0000C081, word 1 reads 0x00000100 and word 2 reads the NEXT_PTR parameter. Writes to these words have no effect. Read data appears on `regRdData` one clock after `regRdEn` is sampled high.
- R2: Word 3 is the status/control word. Bit 0 is the enable flag (read/write). Bit 8 shows the pulse output, bit 16 shows locked and bit 24 shows the error flag. The upper three are read-only. After reset the word reads 0.
- R3: Start time is at words 4..7, period at words 8..11 and width at words 12..15. Within each group the words are, in order: fraction, nanoseconds, seconds bits 31:0, seconds bits 63:32. Reads return the committed value.
- R4: A write to one of the lower three words of a group only stages the data, and readback of that group does not change. Writing the top word commits all four words of the group together.
- R5: A commit to any group clears locked and the error flag at the same clock edge. It then restarts the search: the rising edge is loaded with the start time and the falling edge with start plus width.
- R6: The pulse output is low whenever the block is not locked. Setting enable before lock is allowed and does not produce a pulse.
- R7: While searching, the period is added to both edge times once per clock for as long as the rising edge is earlier than the live time. Locked is set in the first clock that finds the rising edge at or after the live time.
- R8: While locked, the output goes high in the clock in which the live time reaches the rising-edge time, if enable is set. It goes low in the clock in which the live time reaches the falling-edge time. Each edge time then advances by one period.
- R9: Clearing enable stops new rising edges but keeps lock. Setting it again resumes pulses on the same time grid.
- R10: `todStep` sampled high while locked clears locked, sets the error flag and restarts the search. The error flag clears itself when lock is reached again.
- R11: Time sums carry from the fraction into nanoseconds and from nanoseconds into seconds at 1,000,000,000 ns. Comparisons use the full seconds:nanoseconds:fraction value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| todSec | input | 64 | Live time-of-day, seconds |
| todNs | input | 32 | Live time-of-day, nanoseconds |
| todFrac | input | 32 | Live time-of-day, sub-nanosecond fraction |
| todStep | input | 1 | High for one clock when the time source was stepped |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWord | input | 4 | Word address (byte offset divided by four) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid one clock after the read strobe |
| pulseOut | output | 1 | Periodic pulse output |

## Verification
The assertions take the live time to be monotonic between clocks that carry `todStep`. They also assume every nanosecond field, live or programmed, is below one billion, and that a committed period is long enough for the search to terminate. The stimulus advances the time by exactly 8 ns per clock and only makes a jump in the same clock that raises `todStep`. It programs only normalized values with an 80 ns period and a 24 ns width, so every window of 100 locked clocks must contain ten rising edges and thirty high clocks.

// File: rtl/tod_pulse_pkg.sv
package tod_pulse_pkg;
  localparam int SEC_W   = 64;
  localparam int NS_W    = 32;
  localparam int FRAC_W  = 32;
  localparam int WORD_W  = 32;
  localparam int WADDR_W = 4;
  localparam int N_SET   = 3;
  localparam int TIME_W  = SEC_W + NS_W + FRAC_W;

  localparam logic [NS_W-1:0]   NS_PER_SEC    = 32'd1000000000;
  localparam logic [WORD_W-1:0] BLOCK_TYPE    = 32'h0000C081;
  localparam logic [WORD_W-1:0] BLOCK_VERSION = 32'h00000100;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } todTime_t;

  // strobes from control to datapath
  typedef struct packed {
    logic dropLock;
    logic restart;
    logic advance;
    logic track;
    logic riseEn;
  } dpCmd_t;

  typedef enum logic [1:0] {
    LS_IDLE   = 2'd0,
    LS_RELOAD = 2'd1,
    LS_SEARCH = 2'd2,
    LS_LOCKED = 2'd3
  } lockState_e;

  // normalized time addition, both operands must have ns below one second
  function automatic todTime_t todAdd(todTime_t a, todTime_t b);
    logic [FRAC_W:0] fSum;
    logic [NS_W:0]   nSum;
    todTime_t        r;
    fSum   = {1'b0, a.frac} + {1'b0, b.frac};
    nSum   = {1'b0, a.ns} + {1'b0, b.ns} + {{NS_W{1'b0}}, fSum[FRAC_W]};
    r.frac = fSum[FRAC_W-1:0];
    if (nSum >= {1'b0, NS_PER_SEC}) begin
      r.ns  = nSum[NS_W-1:0] - NS_PER_SEC;
      r.sec = a.sec + b.sec + {{(SEC_W-1){1'b0}}, 1'b1};
    end else begin
      r.ns  = nSum[NS_W-1:0];
      r.sec = a.sec + b.sec;
    end
    return r;
  endfunction
endpackage

// File: rtl/tod_pulse_ctrl.sv
module tod_pulse_ctrl
  import tod_pulse_pkg::*;
#(
  parameter logic [WORD_W-1:0] NEXT_PTR = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [WADDR_W-1:0] regWord,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData,
  input  logic               todStep,
  input  logic               riseBehind,
  input  logic               pulseIn,
  output dpCmd_t             cmd,
  output todTime_t           startT,
  output todTime_t           periodT,
  output todTime_t           widthT,
  output logic               lockedOut,
  output logic               errorOut,
  output logic               enableOut
);
  localparam logic [WADDR_W-1:0] W_CTRL = 4'd3;

  logic [1:0]       grpSel;
  logic [1:0]       wordSel;
  logic [N_SET-1:0] commitVec;
  logic             commitAny;
  todTime_t         actArr [N_SET];
  lockState_e       lockSt;
  logic             errQ;
  logic             enableQ;
  logic             stepHit;
  logic [WORD_W-1:0] rdMux;

  assign grpSel  = regWord[3:2];
  assign wordSel = regWord[1:0];

  // one staged group per setting; top word commits the group
  for (genvar g = 0; g < N_SET; g++) begin : gSet
    logic [WORD_W-1:0] stgFrac, stgNs, stgSecLo;
    todTime_t          actReg;
    logic              hit;
    assign hit = regWrEn && (grpSel == 2'(g + 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stgFrac  <= '0;
        stgNs    <= '0;
        stgSecLo <= '0;
        actReg   <= '0;
      end else if (hit) begin
        case (wordSel)
          2'd0: stgFrac  <= regWrData;
          2'd1: stgNs    <= regWrData;
          2'd2: stgSecLo <= regWrData;
          default: actReg <= {regWrData, stgSecLo, stgNs, stgFrac};
        endcase
      end
    end
    assign actArr[g]    = actReg;
    assign commitVec[g] = hit && (wordSel == 2'd3);
  end

  assign commitAny = |commitVec;
  assign startT    = actArr[0];
  assign periodT   = actArr[1];
  assign widthT    = actArr[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= 1'b0;
    else if (regWrEn && regWord == W_CTRL) enableQ <= regWrData[0];
  end

  assign stepHit = todStep && (lockSt != LS_IDLE);

  // lock sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockSt <= LS_IDLE;
      errQ   <= 1'b0;
    end else if (commitAny) begin
      lockSt <= LS_RELOAD;
      errQ   <= 1'b0;
    end else if (stepHit) begin
      lockSt <= LS_RELOAD;
      if (lockSt == LS_LOCKED) errQ <= 1'b1;
    end else begin
      case (lockSt)
        LS_RELOAD: lockSt <= LS_SEARCH;
        LS_SEARCH: if (!riseBehind) begin
          lockSt <= LS_LOCKED;
          errQ   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd.dropLock = commitAny || stepHit;
    cmd.restart  = (lockSt == LS_RELOAD);
    cmd.advance  = (lockSt == LS_SEARCH) && riseBehind;
    cmd.track    = (lockSt == LS_LOCKED);
    cmd.riseEn   = enableQ;
  end

  assign lockedOut = (lockSt == LS_LOCKED);
  assign errorOut  = errQ;
  assign enableOut = enableQ;

  always_comb begin
    todTime_t t;
    t = '0;
    case (grpSel)
      2'd1: t = actArr[0];
      2'd2: t = actArr[1];
      2'd3: t = actArr[2];
      default: t = '0;
    endcase
    case (regWord)
      4'd0: rdMux = BLOCK_TYPE;
      4'd1: rdMux = BLOCK_VERSION;
      4'd2: rdMux = NEXT_PTR;
      4'd3: rdMux = {7'd0, errQ, 7'd0, lockedOut, 7'd0, pulseIn, 7'd0, enableQ};
      default: begin
        case (wordSel)
          2'd0: rdMux = t.frac;
          2'd1: rdMux = t.ns;
          2'd2: rdMux = t.sec[31:0];
          default: rdMux = t.sec[63:32];
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end
endmodule

// File: rtl/tod_pulse_dp.sv
module tod_pulse_dp
  import tod_pulse_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpCmd_t   cmd,
  input  todTime_t nowT,
  input  todTime_t startT,
  input  todTime_t periodT,
  input  todTime_t widthT,
  output logic     riseBehind,
  output logic     pulseOut
);
  todTime_t riseT, fallT;
  todTime_t riseNext, fallNext, fallFirst;
  logic     riseDue, fallDue, riseWins;

  assign riseNext  = todAdd(riseT, periodT);
  assign fallNext  = todAdd(fallT, periodT);
  assign fallFirst = todAdd(startT, widthT);

  assign riseBehind = riseT < nowT;
  assign riseDue    = nowT >= riseT;
  assign fallDue    = nowT >= fallT;
  // when both edges are due, the later one sets the level
  assign riseWins   = riseDue && (!fallDue || riseT >= fallT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseT    <= '0;
      fallT    <= '0;
      pulseOut <= 1'b0;
    end else if (cmd.restart) begin
      riseT    <= startT;
      fallT    <= fallFirst;
      pulseOut <= 1'b0;
    end else if (cmd.dropLock) begin
      pulseOut <= 1'b0;
    end else if (cmd.advance) begin
      riseT <= riseNext;
      fallT <= fallNext;
    end else if (cmd.track) begin
      if (riseDue) riseT <= riseNext;
      if (fallDue) fallT <= fallNext;
      if (riseWins && cmd.riseEn) pulseOut <= 1'b1;
      else if (fallDue)           pulseOut <= 1'b0;
    end
  end
endmodule

// File: rtl/tod_pulse_gen.sv
module tod_pulse_gen
  import tod_pulse_pkg::*;
#(
  parameter logic [31:0] NEXT_PTR = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] todSec,
  input  logic [31:0] todNs,
  input  logic [31:0] todFrac,
  input  logic        todStep,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [3:0]  regWord,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        pulseOut
);
  dpCmd_t   cmd;
  todTime_t nowT, startT, periodT, widthT;
  logic     riseBehind, lockedW, errorW, enableW;

  assign nowT = '{sec: todSec, ns: todNs, frac: todFrac};

  tod_pulse_ctrl #(.NEXT_PTR(NEXT_PTR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWord(regWord),
    .regWrData(regWrData), .regRdData(regRdData),
    .todStep(todStep), .riseBehind(riseBehind), .pulseIn(pulseOut),
    .cmd(cmd), .startT(startT), .periodT(periodT), .widthT(widthT),
    .lockedOut(lockedW), .errorOut(errorW), .enableOut(enableW)
  );

  tod_pulse_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .nowT(nowT),
    .startT(startT), .periodT(periodT), .widthT(widthT),
    .riseBehind(riseBehind), .pulseOut(pulseOut)
  );
endmodule

// File: rtl/tod_pulse_chk.sv
module tod_pulse_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [3:0]  regWord,
  input logic [31:0] regRdData,
  input logic        todStep,
  input logic        pulseOut,
  input logic        lockedW,
  input logic        errorW,
  input logic        enableW
);
  logic commitP;
  assign commitP = regWrEn && (regWord[3:2] != 2'd0) && (regWord[1:0] == 2'd3);

  assert_type_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn && regWord == 4'd0 |=> regRdData == 32'h0000C081);

  assert_commit_unlocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    commitP |=> !lockedW && !errorW);

  assert_low_unlocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    !lockedW |-> !pulseOut);

  assert_relock_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedW) |-> !errorW);

  assert_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> $past(enableW));

  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    lockedW && !commitP && !todStep |=> lockedW);

  assert_step_error_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockedW && todStep && !commitP |=> !lockedW && errorW);
endmodule

bind tod_pulse_gen tod_pulse_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regWord(regWord), .regRdData(regRdData), .todStep(todStep),
  .pulseOut(pulseOut), .lockedW(lockedW), .errorW(errorW), .enableW(enableW)
);

// File: tb/tb_tod_pulse_gen.sv
module tb_tod_pulse_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] tdSec = 64'd5;
  logic [31:0] tdNs = 32'd0;
  logic        todStep = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]  regWord = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pulseOut;

  int checks = 0, fails = 0;
  logic        jumpReq = 1'b0;
  logic [63:0] jSec;
  logic [31:0] jNs;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  localparam logic [31:0] STAT_MASK = 32'h01010001;

  tod_pulse_gen #(.NEXT_PTR(32'h00000240)) dut (
    .clk(clk), .rstN(rstN), .todSec(tdSec), .todNs(tdNs), .todFrac(32'd0),
    .todStep(todStep), .regWrEn(regWrEn), .regRdEn(regRdEn), .regWord(regWord),
    .regWrData(regWrData), .regRdData(regRdData), .pulseOut(pulseOut)
  );

  always #4 clk = ~clk;

  // time source: +8 ns per clock, jumps only together with todStep
  initial forever begin
    @(posedge clk); #1;
    if (jumpReq) begin
      tdSec = jSec; tdNs = jNs; todStep = 1'b1; jumpReq = 1'b0;
    end else begin
      todStep = 1'b0;
      tdNs = tdNs + 32'd8;
      if (tdNs >= 32'd1000000000) begin
        tdNs = tdNs - 32'd1000000000;
        tdSec = tdSec + 64'd1;
      end
    end
  end

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as they appear
  initial forever begin
    logic seen;
    expItem_t it;
    @(posedge clk);
    seen = regRdEn;
    #2;
    if (seen && expQ.size() > 0) begin
      it = expQ.pop_front();
      checkVal(it.tag, regRdData & it.mask, it.exp & it.mask);
    end
  end

  task automatic readCheck(logic [3:0] w, logic [31:0] exp, logic [31:0] mask, string tag);
    expItem_t it;
    it.exp = exp; it.mask = mask; it.tag = tag;
    regWord = w; regRdEn = 1'b1;
    expQ.push_back(it);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic writeReg(logic [3:0] w, logic [31:0] d);
    regWord = w; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic writeSet(logic [3:0] base, logic [31:0] fr, logic [31:0] ns,
                          logic [31:0] sLo, logic [31:0] sHi);
    writeReg(base, fr); writeReg(base + 4'd1, ns);
    writeReg(base + 4'd2, sLo); writeReg(base + 4'd3, sHi);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic jumpTime(logic [63:0] s, logic [31:0] ns);
    jSec = s; jNs = ns; jumpReq = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic pulseWindow(int n, string tag, int expRise, int expHigh);
    logic prev;
    int rises = 0, highs = 0;
    prev = pulseOut;
    repeat (n) begin
      @(posedge clk); #2;
      if (pulseOut && !prev) rises++;
      if (pulseOut) highs++;
      prev = pulseOut;
    end
    @(negedge clk);
    checkVal({tag, " rises"}, rises, expRise);
    checkVal({tag, " high clocks"}, highs, expHigh);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] sNs;
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R1 header, R2 reset state
    readCheck(4'd0, 32'h0000C081, 32'hFFFFFFFF, "R1 type word");
    readCheck(4'd1, 32'h00000100, 32'hFFFFFFFF, "R1 version word");
    writeReg(4'd2, 32'h12345678);
    readCheck(4'd2, 32'h00000240, 32'hFFFFFFFF, "R1 next pointer after write");
    readCheck(4'd3, 32'h0, 32'hFFFFFFFF, "R2 control after reset");
    writeReg(4'd3, 32'hFFFFFFFF);
    readCheck(4'd3, 32'h00000001, 32'hFFFFFFFF, "R2 only enable writable");
    // R6 enabled but never locked
    pulseWindow(20, "R6 enabled while unlocked", 0, 0);
    // R4 staging of start time
    writeReg(4'd4, 32'd0); writeReg(4'd5, 32'd2000); writeReg(4'd6, 32'd5);
    readCheck(4'd5, 32'd0, 32'hFFFFFFFF, "R4 staged ns not visible");
    readCheck(4'd6, 32'd0, 32'hFFFFFFFF, "R4 staged sec not visible");
    writeReg(4'd7, 32'd0);
    readCheck(4'd5, 32'd2000, 32'hFFFFFFFF, "R4 start ns after commit");
    readCheck(4'd6, 32'd5, 32'hFFFFFFFF, "R3 start sec low word");
    writeSet(4'd12, 32'd0, 32'd24, 32'd0, 32'd0);
    writeSet(4'd8, 32'd0, 32'd80, 32'd0, 32'd0);
    readCheck(4'd3, 32'h00000001, STAT_MASK, "R5 unlocked right after commit");
    readCheck(4'd9, 32'd80, 32'hFFFFFFFF, "R3 period ns word");
    readCheck(4'd13, 32'd24, 32'hFFFFFFFF, "R3 width ns word");
    idle(4);
    readCheck(4'd3, 32'h00010001, STAT_MASK, "R7 locked with start in future");
    idle(300);
    pulseWindow(100, "R8 steady pattern", 10, 30);
    // R7 search from a start in the past
    sNs = tdNs - 32'd2400;
    writeSet(4'd4, 32'd0, sNs, 32'd5, 32'd0);
    readCheck(4'd3, 32'h00000001, STAT_MASK, "R5 lock dropped by commit");
    idle(5);
    readCheck(4'd3, 32'h00000001, STAT_MASK, "R7 still searching one period per clock");
    idle(60);
    readCheck(4'd3, 32'h00010001, STAT_MASK, "R7 locked after search");
    pulseWindow(100, "R7 pattern after search", 10, 30);
    // R9 enable gating
    writeReg(4'd3, 32'd0);
    idle(20);
    pulseWindow(100, "R9 disabled", 0, 0);
    readCheck(4'd3, 32'h00010000, STAT_MASK, "R9 lock kept while disabled");
    writeReg(4'd3, 32'd1);
    idle(20);
    pulseWindow(100, "R9 re-enabled", 10, 30);
    // R10 step while locked
    jumpTime(64'd5, tdNs + 32'd16000);
    readCheck(4'd3, 32'h01000001, STAT_MASK, "R10 step sets error drops lock");
    idle(500);
    readCheck(4'd3, 32'h00010001, STAT_MASK, "R10 relock clears error");
    // R5 error cleared by a setting change
    jumpTime(64'd5, tdNs + 32'd60000);
    readCheck(4'd3, 32'h01000001, STAT_MASK, "R10 second step error");
    writeSet(4'd12, 32'd0, 32'd24, 32'd0, 32'd0);
    readCheck(4'd3, 32'h00000001, STAT_MASK, "R5 commit clears error");
    idle(1400);
    readCheck(4'd3, 32'h00010001, STAT_MASK, "R5 relocked after commit");
    // R11 edges across a second boundary
    jumpTime(64'd6, 32'd999999200);
    writeSet(4'd4, 32'd0, 32'd999999600, 32'd6, 32'd0);
    readCheck(4'd5, 32'd999999600, 32'hFFFFFFFF, "R11 start ns near rollover");
    idle(40);
    pulseWindow(100, "R11 pattern across second", 10, 30);
    readCheck(4'd3, 32'h00010001, STAT_MASK, "R11 lock held across second");
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule